// File: doc/BRIEF.md
# Multidrop UART receive address filter

This block sits behind a 9-bit asynchronous receiver, after the deserializer. A single-cycle character strobe delivers each received character to it: eight data bits, a ninth type bit, and framing and parity error indications. The ninth bit gives the character type. A value of 1 means an address character and 0 means a data character. The block decides whether the character is delivered to the holding register. When it is, the block raises the data-available flag.

With filtering enabled, each address character is compared against a programmable node address. A match opens a reception window and a mismatch closes it. Data characters are delivered only while the window is open. The matching address character is itself delivered. With filtering disabled, every character is delivered.

Receive errors are tracked apart from the filter and always reach the interrupt. A mask input suppresses the data part of the interrupt while leaving the error part active.

Top module: `mp_rx_filter`

## Requirements
- R1: After reset the outputs are as follows: `data_avail_o`, `overrun_o`, `frame_err_o`, `parity_err_o` and `irq_o` are 0, `rx_data_o` is 0, the window is closed and the node address is 0.
- R2: A cycle with `addr_we_i`=1 loads `addr_wdata_i` into the node address. With `filt_en_i`=1, a strobed character with `char_mp_i`=1 whose data equals the node address is delivered. Its data appears on `rx_data_o`, `rx_mp_o` reads 1 and `data_avail_o` is 1 one cycle after the strobe.
- R3: With `filt_en_i`=1, two kinds of character are not delivered: an address character that does not match, and a data character (`char_mp_i`=0) while the window is closed. For these, `rx_data_o`, `rx_mp_o` and `data_avail_o` keep their previous values.
- R4: A matching address opens the window. Data characters that follow are delivered until the next address character. A non-matching address closes the window. A cycle with `filt_en_i`=0 also closes it.
- R5: With `filt_en_i`=0 every strobed character is delivered, whatever its type bit.
- R6: A cycle with `rd_i`=1 clears `data_avail_o` and `overrun_o`. A delivered character that arrives while `data_avail_o`=1 and `rd_i`=0 sets `overrun_o`. A delivered character in the same cycle as `rd_i`=1 leaves `data_avail_o` at 1 and does not set `overrun_o`.
- R7: `frame_err_o` and `parity_err_o` are set one cycle after a strobe carrying `char_frame_err_i` or `char_parity_err_i`, whatever the filter and window state. They stay set until a cycle with `rd_i`=1 and no new error; when both fall in one cycle, the new error wins.
- R8: `irq_o` = `frame_err_o` | `parity_err_o` | `overrun_o` | (`data_avail_o` & ~`data_irq_mask_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Node address write strobe |
| addr_wdata_i | input | 8 | Node address write value |
| filt_en_i | input | 1 | Address filter enable |
| data_irq_mask_i | input | 1 | 1 masks data interrupts; error interrupts stay |
| char_valid_i | input | 1 | Character strobe, one cycle per character |
| char_data_i | input | 8 | Received data bits |
| char_mp_i | input | 1 | Type bit: 1 address, 0 data |
| char_frame_err_i | input | 1 | Framing error on this character |
| char_parity_err_i | input | 1 | Parity error on this character |
| rd_i | input | 1 | Holding register read strobe |
| rx_data_o | output | 8 | Last delivered data |
| rx_mp_o | output | 1 | Type bit of the last delivered character |
| data_avail_o | output | 1 | Delivered character awaiting read |
| overrun_o | output | 1 | Delivered character overwrote an unread one |
| frame_err_o | output | 1 | Sticky framing error |
| parity_err_o | output | 1 | Sticky parity error |
| irq_o | output | 1 | Receive interrupt request |

## Verification
Two events can fall in the same cycle: a read strobe and a newly delivered character, and a read strobe and a new error. The sweep provokes both by deriving `rd_i` and the strobe fields from independent bits of the iteration index, so every pairing of read, character type, address match, window state, filter and mask occurs. Each cycle is compared against an arithmetic model that applies the set-wins-over-clear rules of R6 and R7.

// File: rtl/mp_rx_filter_pkg.sv
package mp_rx_filter_pkg;
  parameter int unsigned DATA_W = 8;
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              mp;
    logic              frame_err;
    logic              parity_err;
  } rx_char_t;
endpackage

// File: rtl/mpf_addr_match.sv
module mpf_addr_match
  import mp_rx_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic [DATA_W-1:0] addr_wdata_i,
  input  logic              filt_en_i,
  input  logic              valid_i,
  input  rx_char_t          char_i,
  output logic              accept_o
);
  logic [DATA_W-1:0] node_q;
  logic              win_q;
  logic              hit;

  assign hit = (char_i.data == node_q);

  always_comb begin
    if (!filt_en_i)      accept_o = valid_i;
    else if (char_i.mp)  accept_o = valid_i & hit;
    else                 accept_o = valid_i & win_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      node_q <= '0;
      win_q  <= 1'b0;
    end else begin
      if (addr_we_i) node_q <= addr_wdata_i;
      if (!filt_en_i)                win_q <= 1'b0;
      else if (valid_i && char_i.mp) win_q <= hit;
    end
  end
endmodule

// File: rtl/mpf_rx_hold.sv
module mpf_rx_hold
  import mp_rx_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  rx_char_t          char_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mp_o,
  output logic              avail_o,
  output logic              overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      mp_o      <= 1'b0;
      avail_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (accept_i) begin
        data_o  <= char_i.data;
        mp_o    <= char_i.mp;
        avail_o <= 1'b1;
      end else if (rd_i) begin
        avail_o <= 1'b0;
      end
      if (accept_i && avail_o && !rd_i) overrun_o <= 1'b1;
      else if (rd_i)                    overrun_o <= 1'b0;
    end
  end

  p_avail_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> avail_o);
  p_rd_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !accept_i) |=> (!avail_o && !overrun_o));
  p_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && avail_o && !rd_i) |=> overrun_o);
  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($stable(data_o) && $stable(mp_o)));
endmodule

// File: rtl/mpf_err_track.sv
module mpf_err_track
  import mp_rx_filter_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  rx_char_t char_i,
  input  logic     rd_i,
  output logic     frame_o,
  output logic     parity_o
);
  logic fe_set, pe_set;
  assign fe_set = valid_i & char_i.frame_err;
  assign pe_set = valid_i & char_i.parity_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o  <= 1'b0;
      parity_o <= 1'b0;
    end else begin
      if (fe_set)    frame_o <= 1'b1;
      else if (rd_i) frame_o <= 1'b0;
      if (pe_set)    parity_o <= 1'b1;
      else if (rd_i) parity_o <= 1'b0;
    end
  end

  p_frame_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && char_i.frame_err) |=> frame_o);
  p_parity_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_o && !rd_i) |=> parity_o);
endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter
  import mp_rx_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic [DATA_W-1:0] addr_wdata_i,
  input  logic              filt_en_i,
  input  logic              data_irq_mask_i,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_mp_i,
  input  logic              char_frame_err_i,
  input  logic              char_parity_err_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_mp_o,
  output logic              data_avail_o,
  output logic              overrun_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              irq_o
);
  rx_char_t ch;
  logic     accept;
  logic     err_any;

  assign ch = '{data: char_data_i, mp: char_mp_i,
                frame_err: char_frame_err_i, parity_err: char_parity_err_i};

  mpf_addr_match u_match (
    .clk_i, .rst_ni, .addr_we_i, .addr_wdata_i, .filt_en_i,
    .valid_i(char_valid_i), .char_i(ch), .accept_o(accept));

  mpf_rx_hold u_hold (
    .clk_i, .rst_ni, .accept_i(accept), .char_i(ch), .rd_i,
    .data_o(rx_data_o), .mp_o(rx_mp_o), .avail_o(data_avail_o),
    .overrun_o(overrun_o));

  mpf_err_track u_err (
    .clk_i, .rst_ni, .valid_i(char_valid_i), .char_i(ch), .rd_i,
    .frame_o(frame_err_o), .parity_o(parity_err_o));

  assign err_any = frame_err_o | parity_err_o | overrun_o;
  assign irq_o   = err_any | (data_avail_o & ~data_irq_mask_i);

  p_mask_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_irq_mask_i && !frame_err_o && !parity_err_o && !overrun_o) |-> !irq_o);
  p_err_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> irq_o);
  p_filter_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!filt_en_i && char_valid_i) |-> accept);
endmodule

// File: tb/mp_rx_filter_tb.sv
module mp_rx_filter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, filt = 0, mask = 0, vld = 0, mp = 0, fe = 0, pe = 0, rd = 0;
  logic [7:0] wdata = 0, din = 0;
  logic [7:0] rx_data;
  logic rx_mp, avail, ovr, ferr, perr, irq;
  int checks = 0, errors = 0;

  logic [7:0] m_addr = 0, m_data = 0;
  logic m_mp = 0, m_win = 0, m_av = 0, m_ovr = 0, m_fe = 0, m_pe = 0;

  always #2 clk = ~clk;

  mp_rx_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_we_i(we), .addr_wdata_i(wdata),
    .filt_en_i(filt), .data_irq_mask_i(mask), .char_valid_i(vld),
    .char_data_i(din), .char_mp_i(mp), .char_frame_err_i(fe),
    .char_parity_err_i(pe), .rd_i(rd), .rx_data_o(rx_data), .rx_mp_o(rx_mp),
    .data_avail_o(avail), .overrun_o(ovr), .frame_err_o(ferr),
    .parity_err_o(perr), .irq_o(irq));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string av_tag);
    chk(av_tag, {7'd0, avail}, {7'd0, m_av});
    chk("R3 rx_data", rx_data, m_data);
    chk("R3 rx_mp", {7'd0, rx_mp}, {7'd0, m_mp});
    chk("R6 overrun", {7'd0, ovr}, {7'd0, m_ovr});
    chk("R7 frame", {7'd0, ferr}, {7'd0, m_fe});
    chk("R7 parity", {7'd0, perr}, {7'd0, m_pe});
    chk("R8 irq", {7'd0, irq}, {7'd0, m_fe | m_pe | m_ovr | (m_av & ~mask)});
  endtask

  // one cycle: drive at negedge, model and compare just after posedge
  task automatic step(logic f, logic k, logic v, logic t, logic [7:0] d,
                      logic e1, logic e2, logic r, string av_tag);
    logic acc, hit;
    @(negedge clk);
    filt = f; mask = k; vld = v; mp = t; din = d; fe = e1; pe = e2; rd = r;
    hit = (d == m_addr);
    acc = v && (!f || (t ? hit : m_win));
    @(posedge clk); #1;
    if (acc && m_av && !r) m_ovr = 1; else if (r) m_ovr = 0;
    if (acc) begin m_data = d; m_mp = t; m_av = 1; end else if (r) m_av = 0;
    if (v && e1) m_fe = 1; else if (r) m_fe = 0;
    if (v && e2) m_pe = 1; else if (r) m_pe = 0;
    if (!f) m_win = 0; else if (v && t) m_win = hit;
    compare_all(av_tag);
  endtask

  task automatic write_addr(logic [7:0] a);
    @(negedge clk); we = 1; wdata = a;
    @(negedge clk); we = 0; m_addr = a;
  endtask

  task automatic sweep(int n);
    for (int i = 0; i < n; i++) begin
      logic f, t;
      logic [7:0] d;
      f = ~i[8];
      t = i[0] ^ i[3];
      d = i[1] ? m_addr : 8'(i * 37 + 1);
      step(f, i[5], i[2] | i[6], t, d, (i % 7) == 0, (i % 11) == 0,
           i[2] & i[4], f ? "R4 avail window" : "R5 avail filter off");
    end
  endtask

  initial begin
    #2000000; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1; compare_all("R1 reset avail");
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1; compare_all("R1 after release");
    // R1: node address resets to 0, so address 0 matches
    step(1, 0, 1, 1, 8'h00, 0, 0, 0, "R1 node addr zero");
    step(1, 0, 0, 0, 0, 0, 0, 1, "R6 read clear");
    write_addr(8'h5A);
    // R2 match, R3 mismatch/closed, R4 window
    step(1, 0, 1, 1, 8'h5A, 0, 0, 1, "R2 match");
    step(1, 0, 1, 0, 8'h11, 0, 0, 1, "R4 data in window");
    step(1, 0, 1, 1, 8'h5B, 0, 0, 1, "R3 mismatch addr");
    step(1, 0, 1, 0, 8'h22, 0, 0, 0, "R3 data window closed");
    // R6 same cycle read and char, then overrun
    step(0, 0, 1, 0, 8'h33, 0, 0, 0, "R5 deliver");
    step(0, 0, 1, 0, 8'h44, 0, 0, 1, "R6 read with char");
    step(0, 1, 1, 0, 8'h55, 1, 0, 0, "R6 overrun");
    step(1, 1, 1, 0, 8'h66, 0, 1, 1, "R7 error filtered");
    sweep(1024);
    write_addr(8'hC3);
    sweep(512);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule